// File: doc/BRIEF.md
# Packed half-precision to unsigned integer converter

This block turns a vector of up to sixteen IEEE 754 half-precision numbers into 32-bit unsigned integers. Each value is rounded toward zero. A value that has no unsigned 32-bit result yields the all-ones indefinite pattern and raises an invalid flag. A value whose fraction is discarded raises a precision flag. Both flags are sticky.

Every lane has a write-enable mask. A lane that is masked off either keeps the caller's prior destination value (merge) or is cleared (zeroing). A broadcast option feeds source element 0 to every lane. The destination width is 128, 256 or 512 bits. Result bits above the chosen width are always cleared.

The conversion is combinational. Its result is captured in one output register on each cycle where `en_i` is high, so the result appears at the ports one clock after the request.

Top module: `pk_h2u_cvt`

## Requirements
- R1: `vlen_i` selects the number of active lanes: 2'b00 gives lanes 0-3, 2'b01 gives lanes 0-7, and 2'b10 or 2'b11 gives all 16 lanes. Lane j reads `src_i[16j+15:16j]` and writes `res_o[32j+31:32j]`.
- R2: A finite, non-negative half value in an active, written lane produces its integer part, rounded toward zero. The largest such value is 65504, which gives 0x0000FFE0.
- R3: NaN, either infinity, and any value less than or equal to -1.0 produce 0xFFFFFFFF in a written lane and set `invalid_o`.
- R4: Both signed zeros produce 0 and raise no flag. Subnormals and negative values greater than -1.0 produce 0 and set `precision_o`.
- R5: An active lane is written with its conversion when `mask_en_i` is 0, or when its bit in `mask_i` is 1.
- R6: An active lane that is not written takes the value 0 when `zero_i` is 1. Otherwise it takes its slice of `prev_i`.
- R7: When `bcast_i` is 1, every active lane converts `src_i[15:0]`.
- R8: Every result bit from the active width up to bit 511 is 0.
- R9: `precision_o` is set when a written lane discards nonzero fraction bits. A lane that is invalid does not also set `precision_o`. Lanes that are not written, and lanes that are inactive, set neither flag.
- R10: `res_o` loads on a clock edge where `en_i` is 1 and holds otherwise. Both flags stay set until reset.
- R11: While `rst_ni` is low, `res_o` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Capture the conversion this cycle |
| vlen_i | input | 2 | Destination width select |
| mask_en_i | input | 1 | Apply the lane mask |
| mask_i | input | 16 | Per-lane write mask |
| zero_i | input | 1 | Clear unwritten lanes instead of merging |
| bcast_i | input | 1 | Feed source element 0 to all lanes |
| src_i | input | 256 | Packed half-precision source |
| prev_i | input | 512 | Prior destination value for merging |
| res_o | output | 512 | Converted, masked result |
| invalid_o | output | 1 | Sticky invalid flag |
| precision_o | output | 1 | Sticky precision flag |

## Verification
The only state in the block is the result register and the two sticky flags. A lane-select or mask fault therefore shows up in `res_o` one clock after the faulty capture, as a wrong lane value or as nonzero bits above the active width.

A flag fault can hide behind stickiness, because an earlier error stays set. For that reason each table vector starts from a fresh reset and its flags are read right after the single capture. A register that fails to hold shows up on the first idle cycle with changed inputs.

// File: rtl/pk_h2u_pkg.sv
package pk_h2u_pkg;
  localparam int H_W     = 16;
  localparam int H_EXP_W = 5;
  localparam int H_MAN_W = 10;
  localparam int U_W     = 32;

  typedef enum logic [1:0] {
    VL_Q   = 2'b00,
    VL_H   = 2'b01,
    VL_F   = 2'b10,
    VL_FX  = 2'b11
  } vlen_e;

  typedef struct packed {
    logic [U_W-1:0] val;
    logic           inv;
    logic           inx;
  } conv_t;

  // active lane count for a width code
  function automatic int unsigned lanes_for(input logic [1:0] code, input int unsigned lanes);
    case (vlen_e'(code))
      VL_Q:    return lanes / 4;
      VL_H:    return lanes / 2;
      default: return lanes;
    endcase
  endfunction
endpackage

// File: rtl/pk_h2u_lane.sv
module pk_h2u_lane
  import pk_h2u_pkg::*;
#(
  parameter int HW = H_W,
  parameter int EW = H_EXP_W,
  parameter int MW = H_MAN_W,
  parameter int UW = U_W
) (
  input  logic [HW-1:0] h_i,
  output logic [UW-1:0] val_o,
  output logic          inv_o,
  output logic          inx_o
);
  localparam int BIAS  = (1 << (EW - 1)) - 1;
  localparam int PT    = BIAS + MW;          // binary point position in wide
  localparam int WW    = MW + (1 << EW) + 1; // room for max shift
  localparam int IW    = WW - PT;

  logic          sgn;
  logic [EW-1:0] exp_f;
  logic [MW-1:0] man;
  logic [MW:0]   sig;
  logic [EW-1:0] eff;
  logic [WW-1:0] wide;
  logic [IW-1:0] ipart;
  logic          frac_nz;
  logic          special;
  logic          neg_big;
  logic          ovf;

  assign sgn   = h_i[HW-1];
  assign exp_f = h_i[HW-2 -: EW];
  assign man   = h_i[MW-1:0];

  // subnormals use exponent 1 with no hidden bit
  assign sig     = {|exp_f, man};
  assign eff     = (exp_f == '0) ? EW'(1) : exp_f;
  assign wide    = WW'(sig) << eff;
  assign ipart   = wide[WW-1:PT];
  assign frac_nz = |wide[PT-1:0];
  assign special = &exp_f;
  assign neg_big = sgn & (|ipart);

  generate
    if (IW > UW) begin : g_ovf
      assign ovf = ~sgn & (|ipart[IW-1:UW]);
    end else begin : g_no_ovf
      assign ovf = 1'b0;
    end
  endgenerate

  always_comb begin
    inv_o = special | neg_big | ovf;
    inx_o = ~inv_o & frac_nz;
    if (inv_o)     val_o = '1;
    else if (sgn)  val_o = '0;
    else           val_o = UW'(ipart);
  end
endmodule

// File: rtl/pk_h2u_merge.sv
module pk_h2u_merge #(
  parameter int UW = 32
) (
  input  logic          active_i,
  input  logic          wr_i,
  input  logic          zero_i,
  input  logic [UW-1:0] conv_i,
  input  logic [UW-1:0] prev_i,
  output logic [UW-1:0] out_o
);
  always_comb begin
    if (!active_i)    out_o = '0;
    else if (wr_i)    out_o = conv_i;
    else if (zero_i)  out_o = '0;
    else              out_o = prev_i;
  end
endmodule

// File: rtl/pk_h2u_flags.sv
module pk_h2u_flags #(
  parameter int LANES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LANES-1:0] take_i,
  input  logic [LANES-1:0] inv_i,
  input  logic [LANES-1:0] inx_i,
  output logic             invalid_o,
  output logic             precision_o
);
  logic inv_any, inx_any;

  assign inv_any = |(take_i & inv_i);
  assign inx_any = |(take_i & inx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      invalid_o   <= 1'b0;
      precision_o <= 1'b0;
    end else if (en_i) begin
      invalid_o   <= invalid_o | inv_any;
      precision_o <= precision_o | inx_any;
    end
  end
endmodule

// File: rtl/pk_h2u_cvt.sv
module pk_h2u_cvt
  import pk_h2u_pkg::*;
#(
  parameter int LANES = 16,
  parameter int HW    = H_W,
  parameter int UW    = U_W,
  localparam int SW   = LANES * HW,
  localparam int RW   = LANES * UW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       vlen_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             zero_i,
  input  logic             bcast_i,
  input  logic [SW-1:0]    src_i,
  input  logic [RW-1:0]    prev_i,
  output logic [RW-1:0]    res_o,
  output logic             invalid_o,
  output logic             precision_o
);
  int unsigned      n_act;
  logic [LANES-1:0] active;
  logic [LANES-1:0] wr;
  logic [LANES-1:0] take;
  logic [LANES-1:0] l_inv;
  logic [LANES-1:0] l_inx;
  logic [RW-1:0]    res_d;

  assign n_act = lanes_for(vlen_i, LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [HW-1:0] h_src;
    logic [UW-1:0] conv;

    assign active[j] = (j < n_act);
    assign wr[j]     = ~mask_en_i | mask_i[j];
    assign take[j]   = active[j] & wr[j];
    assign h_src     = bcast_i ? src_i[HW-1:0] : src_i[j*HW +: HW];

    pk_h2u_lane #(.HW(HW), .UW(UW)) u_cvt (
      .h_i   (h_src),
      .val_o (conv),
      .inv_o (l_inv[j]),
      .inx_o (l_inx[j])
    );

    pk_h2u_merge #(.UW(UW)) u_mrg (
      .active_i (active[j]),
      .wr_i     (wr[j]),
      .zero_i   (zero_i),
      .conv_i   (conv),
      .prev_i   (prev_i[j*UW +: UW]),
      .out_o    (res_d[j*UW +: UW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (en_i)  res_o <= res_d;
  end

  pk_h2u_flags #(.LANES(LANES)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .take_i      (take),
    .inv_i       (l_inv),
    .inx_i       (l_inx),
    .invalid_o   (invalid_o),
    .precision_o (precision_o)
  );
endmodule

// File: rtl/pk_h2u_cvt_chk.sv
module pk_h2u_cvt_chk #(
  parameter int LANES = 16,
  parameter int HW    = 16,
  parameter int UW    = 32,
  localparam int SW   = LANES * HW,
  localparam int RW   = LANES * UW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       vlen_i,
  input logic             mask_en_i,
  input logic [LANES-1:0] mask_i,
  input logic             zero_i,
  input logic             bcast_i,
  input logic [SW-1:0]    src_i,
  input logic [RW-1:0]    prev_i,
  input logic [RW-1:0]    res_o,
  input logic             invalid_o,
  input logic             precision_o
);
  assert_upper_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && vlen_i == 2'b00 |=> res_o[RW-1:RW/4] == '0);

  assert_merge_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mask_en_i && !mask_i[0] && !zero_i |=> res_o[UW-1:0] == $past(prev_i[UW-1:0]));

  assert_zero_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mask_en_i && !mask_i[0] && zero_i |=> res_o[UW-1:0] == '0);

  assert_bcast_same_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && bcast_i && !mask_en_i |=> res_o[2*UW-1:UW] == res_o[UW-1:0]);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(res_o));

  assert_inv_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |=> invalid_o);

  assert_prec_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    precision_o |=> precision_o);

  assert_flag_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(invalid_o) || $rose(precision_o) |-> $past(en_i));
endmodule

bind pk_h2u_cvt pk_h2u_cvt_chk #(.LANES(LANES), .HW(HW), .UW(UW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .vlen_i      (vlen_i),
  .mask_en_i   (mask_en_i),
  .mask_i      (mask_i),
  .zero_i      (zero_i),
  .bcast_i     (bcast_i),
  .src_i       (src_i),
  .prev_i      (prev_i),
  .res_o       (res_o),
  .invalid_o   (invalid_o),
  .precision_o (precision_o)
);

// File: tb/pk_h2u_cvt_bench.sv
module pk_h2u_cvt_bench;
  localparam int NV = 17;
  // {fp16, expected u32, invalid, precision}
  localparam logic [49:0] VEC [NV] = '{
    {16'h0000, 32'h0000_0000, 1'b0, 1'b0},
    {16'h8000, 32'h0000_0000, 1'b0, 1'b0},
    {16'h3C00, 32'h0000_0001, 1'b0, 1'b0},
    {16'h3E00, 32'h0000_0001, 1'b0, 1'b1},
    {16'h4500, 32'h0000_0005, 1'b0, 1'b0},
    {16'h7BFF, 32'h0000_FFE0, 1'b0, 1'b0},
    {16'h3800, 32'h0000_0000, 1'b0, 1'b1},
    {16'h0001, 32'h0000_0000, 1'b0, 1'b1},
    {16'hB800, 32'h0000_0000, 1'b0, 1'b1},
    {16'hBC00, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {16'h7C00, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {16'hFC00, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {16'h7E00, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {16'h6400, 32'h0000_0400, 1'b0, 1'b0},
    {16'h4DFF, 32'h0000_0017, 1'b0, 1'b1},
    {16'hC000, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {16'h5A00, 32'h0000_00C0, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [1:0]   vlen = 2'b10;
  logic         mask_en = 1'b0;
  logic [15:0]  mask = '0;
  logic         zero = 1'b0;
  logic         bcast = 1'b0;
  logic [255:0] src = '0;
  logic [511:0] prev = '0;
  logic [511:0] res;
  logic         inv, prec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pk_h2u_cvt u_pk_h2u_cvt (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vlen_i(vlen), .mask_en_i(mask_en),
    .mask_i(mask), .zero_i(zero), .bcast_i(bcast), .src_i(src), .prev_i(prev),
    .res_o(res), .invalid_o(inv), .precision_o(prec)
  );

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input logic [1:0] vl, input logic me, input logic [15:0] mk,
                     input logic zr, input logic bc, input logic [255:0] s, input logic [511:0] p);
    @(negedge clk);
    vlen = vl; mask_en = me; mask = mk; zero = zr; bcast = bc; src = s; prev = p;
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  // fp16 encoding of an integer 1..16
  function automatic logic [15:0] h_of(input int n);
    int e = 0;
    for (int b = 0; b < 5; b++) if (n >= (1 << b)) e = b;
    return {1'b0, 5'(15 + e), 10'((n << (10 - e)) & 'h3FF)};
  endfunction

  function automatic logic [255:0] ramp_src();
    logic [255:0] s = '0;
    for (int j = 0; j < 16; j++) s[j*16 +: 16] = h_of(j + 1);
    return s;
  endfunction

  function automatic logic [511:0] prev_pat();
    logic [511:0] p = '0;
    for (int j = 0; j < 16; j++) p[j*32 +: 32] = 32'hDEAD_0000 | 32'(j);
    return p;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] exp;
    logic [15:0]  mk;

    // R11 reset state
    @(negedge clk);
    chk("R11 res in reset", res, '0);
    chk("R11 inv in reset", {511'b0, inv}, '0);
    chk("R11 prec in reset", {511'b0, prec}, '0);
    rst_n = 1'b1;

    // table: broadcast each value over all lanes (R2 R3 R4 R9)
    for (int i = 0; i < NV; i++) begin
      do_reset();
      run(2'b10, 1'b0, '0, 1'b0, 1'b0, {16{VEC[i][49:34]}}, '0);
      chk($sformatf("R2 R3 R4 value %h", VEC[i][49:34]), res, {16{VEC[i][33:2]}});
      chk($sformatf("R3 inv for %h", VEC[i][49:34]), {511'b0, inv}, {511'b0, VEC[i][1]});
      chk($sformatf("R4 R9 prec for %h", VEC[i][49:34]), {511'b0, prec}, {511'b0, VEC[i][0]});
    end

    // R1 R8: quarter width, prev all ones must not leak
    do_reset();
    run(2'b00, 1'b0, '0, 1'b0, 1'b0, ramp_src(), '1);
    exp = '0;
    for (int j = 0; j < 4; j++) exp[j*32 +: 32] = 32'(j + 1);
    chk("R1 R8 width 128", res, exp);

    run(2'b01, 1'b0, '0, 1'b0, 1'b0, ramp_src(), '1);
    exp = '0;
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = 32'(j + 1);
    chk("R1 R8 width 256", res, exp);

    run(2'b11, 1'b0, '0, 1'b0, 1'b0, ramp_src(), '1);
    for (int j = 0; j < 16; j++) exp[j*32 +: 32] = 32'(j + 1);
    chk("R1 width code 3", res, exp);

    // R5 R6 merge
    mk = 16'hA5A5;
    run(2'b10, 1'b1, mk, 1'b0, 1'b0, ramp_src(), prev_pat());
    for (int j = 0; j < 16; j++)
      exp[j*32 +: 32] = mk[j] ? 32'(j + 1) : (32'hDEAD_0000 | 32'(j));
    chk("R5 R6 merge", res, exp);

    // R5 R6 zeroing
    run(2'b10, 1'b1, mk, 1'b1, 1'b0, ramp_src(), prev_pat());
    for (int j = 0; j < 16; j++) exp[j*32 +: 32] = mk[j] ? 32'(j + 1) : 32'h0;
    chk("R5 R6 zeroing", res, exp);

    // R9: masked-off NaN and fractional lanes raise nothing
    do_reset();
    run(2'b10, 1'b1, 16'h0001, 1'b1, 1'b0, {{15{16'h7E00}}, 16'h3C00}, '0);
    chk("R9 masked lanes value", res, 512'h1);
    chk("R9 masked no inv", {511'b0, inv}, '0);
    run(2'b00, 1'b0, '0, 1'b0, 1'b0, {{12{16'h3E00}}, {4{16'h4000}}}, '0);
    chk("R9 inactive no prec", {511'b0, prec}, '0);

    // R7 broadcast ignores other elements
    run(2'b10, 1'b0, '0, 1'b0, 1'b1, {ramp_src()[255:16], 16'h4500}, '0);
    chk("R7 broadcast", res, {16{32'h5}});

    // R10 sticky and hold
    run(2'b10, 1'b0, '0, 1'b0, 1'b0, {16{16'h3E00}}, '0);
    run(2'b10, 1'b0, '0, 1'b0, 1'b0, {16{16'h7E00}}, '0);
    run(2'b10, 1'b0, '0, 1'b0, 1'b0, {16{16'h3C00}}, '0);
    chk("R10 prec sticky", {511'b0, prec}, 512'h1);
    chk("R10 inv sticky", {511'b0, inv}, 512'h1);
    chk("R10 result after exact", res, {16{32'h1}});
    @(negedge clk);
    src = {16{16'h4500}}; zero = 1'b1; mask_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold without en", res, {16{32'h1}});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule